// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank State Tracker

This block watches the command pins of a DDR SDRAM bus from the controller side. On every rising clock edge it samples chip select, the three command strobes, the bank address and address bit 10. It turns them into one command code and follows the life of every bank: idle, opening a row, row open, read burst, write burst, write recovery, closing and refreshing. The state changes use cycle counts set by parameters. For each command it raises a registered flag when the command is not allowed in the current state of the bank it targets. An illegal command has no effect on any bank.

A controller design or a bus monitor can place the block next to its own sequencer. It can then see at once when a command breaks the per-bank ordering rules: column access to a closed bank, a second open, a refresh while a row is open, or a burst stop on the wrong kind of burst. One bit of clock-enable handling is included. While clock enable is low the pins are ignored and a power-down flag is shown.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With chip select high the command is a deselect. With chip select low, the pins {ras_n,cas_n,we_n} decode as follows: 011 open row, 101 read, 100 write, 010 precharge, 001 auto-refresh, 000 mode register set, 110 burst stop, 111 no operation. One cycle after the sampling edge, cmd_o reports the code: 0 deselect, 1 no operation, 2 open row, 3 read, 4 read with auto-precharge, 5 write, 6 write with auto-precharge, 7 precharge one bank, 8 precharge all, 9 refresh, 10 base mode register, 11 extended mode register, 12 reserved mode register target, 13 burst stop.
- R2: During a mode register set, ba=0 selects the base register (code 10) and ba=1 selects the extended register (code 11). ba=2 or ba=3 gives code 12 and is flagged illegal. A mode register set is illegal unless every bank is idle.
- R3: illegal_o is registered. It is high in the cycle after an illegal command and low after a legal one, so each offending command gives exactly one high cycle. An illegal command leaves the banks evolving exactly as under a no operation.
- R4: bank_st_o bits [3b+2:3b] hold the state of bank b: 0 idle, 1 opening, 2 row open, 3 reading, 4 writing, 5 write recovery, 6 precharging, 7 refreshing. An open-row command to an idle bank makes it opening for T_RCD cycles and then row open. An open-row command to a bank that is not idle is illegal.
- R5: A read or write to a bank that is idle, opening, precharging, in write recovery or refreshing is illegal.
- R6: A read to a row-open bank makes it reading for T_BURST cycles, after which it returns to row open. A read during a read burst without auto-precharge restarts the burst. A write during that read burst is illegal.
- R7: A burst stop is legal only while the target bank is reading without auto-precharge, and it returns that bank to row open at once. In any other state, including a write burst and an auto-precharge read, it is illegal.
- R8: A write to a row-open bank makes it writing for T_BURST cycles, then write recovery for T_WR cycles, then row open.
- R9: A read with auto-precharge goes straight from the end of its burst to precharging. A write with auto-precharge goes from the end of write recovery to precharging. Precharging lasts T_RP cycles and ends in idle. While the bank is in that auto-precharge burst, any read, write or burst stop to it is illegal.
- R10: With a10=0 a precharge targets bank ba. A bank that is row open, or reading or writing without auto-precharge, becomes precharging for T_RP cycles and then idle. The command has no effect on an idle or precharging bank. It is illegal on an opening, write-recovery, refreshing or auto-precharge-burst bank. With a10=1 the precharge applies to all banks, and it is illegal if any one bank would refuse it.
- R11: Auto-refresh is legal only when every bank is idle. It puts all banks into refreshing for T_RFC cycles, after which they return to idle.
- R12: While cke is low the command pins are ignored. One cycle later pd_o is high, cmd_o is 0 and illegal_o is low, and no bank changes because of the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; low ignores the command pins |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | $clog2(NB) | Bank address |
| a10 | input | 1 | Auto-precharge / precharge-all select |
| cmd_o | output | 4 | Registered decoded command code |
| illegal_o | output | 1 | Registered illegal-command flag |
| pd_o | output | 1 | Registered power-down flag |
| bank_st_o | output | 3*NB | Per-bank state, 3 bits per bank |

## Verification
The bench first sends, from an all-idle start, a table of pin patterns that never change a bank: every strobe combination, both mode register targets, the reserved ones, and column accesses and burst stops to closed banks. This separates pure decoding from state tracking. Directed sequences then place back-to-back commands on single cycles inside timed windows. A read restart, a burst stop and an illegal write land one cycle into a read burst, so a missed restart or a missed stop shows up as a state that ends too early or too late. The auto-precharge, all-bank precharge and refresh sequences are sampled on the last cycle of each window and on the first cycle after it, which exposes off-by-one counters and wrong successor states.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [3:0] {
    C_DESEL  = 4'd0,
    C_NOP    = 4'd1,
    C_ACT    = 4'd2,
    C_RD     = 4'd3,
    C_RDA    = 4'd4,
    C_WR     = 4'd5,
    C_WRA    = 4'd6,
    C_PRE    = 4'd7,
    C_PREA   = 4'd8,
    C_REF    = 4'd9,
    C_MRS    = 4'd10,
    C_EMRS   = 4'd11,
    C_MRSX   = 4'd12,
    C_STOP   = 4'd13
  } cmd_e;

  typedef enum logic [2:0] {
    B_IDLE    = 3'd0,
    B_OPENING = 3'd1,
    B_OPEN    = 3'd2,
    B_READ    = 3'd3,
    B_WRITE   = 3'd4,
    B_WRREC   = 3'd5,
    B_CLOSING = 3'd6,
    B_REFRESH = 3'd7
  } bank_st_e;

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
#(
  parameter int BAW = 2
) (
  input  logic           cs_n,
  input  logic           ras_n,
  input  logic           cas_n,
  input  logic           we_n,
  input  logic [BAW-1:0] ba,
  input  logic           a10,
  output cmd_e           cmd
);

  always_comb begin
    cmd = C_DESEL;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011: cmd = C_ACT;
        3'b101: cmd = a10 ? C_RDA : C_RD;
        3'b100: cmd = a10 ? C_WRA : C_WR;
        3'b010: cmd = a10 ? C_PREA : C_PRE;
        3'b001: cmd = C_REF;
        3'b000: begin
          if (ba == BAW'(0))      cmd = C_MRS;
          else if (ba == BAW'(1)) cmd = C_EMRS;
          else                    cmd = C_MRSX;
        end
        3'b110: cmd = C_STOP;
        default: cmd = C_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdcmd_legal.sv
module sdcmd_legal
  import sdcmd_pkg::*;
#(
  parameter int NB  = 4,
  parameter int BAW = 2
) (
  input  cmd_e           cmd,
  input  logic [BAW-1:0] ba,
  input  bank_st_e       st_i [NB],
  input  logic [NB-1:0]  ap_i,
  output logic           legal
);

  function automatic logic can_close(bank_st_e s, logic ap);
    return (s == B_IDLE) || (s == B_CLOSING) || (s == B_OPEN) ||
           (((s == B_READ) || (s == B_WRITE)) && !ap);
  endfunction

  logic     all_idle, all_close;
  bank_st_e s;
  logic     a;

  always_comb begin
    all_idle  = 1'b1;
    all_close = 1'b1;
    for (int b = 0; b < NB; b++) begin
      all_idle  = all_idle  & (st_i[b] == B_IDLE);
      all_close = all_close & can_close(st_i[b], ap_i[b]);
    end
    s = st_i[ba];
    a = ap_i[ba];
    case (cmd)
      C_ACT:          legal = (s == B_IDLE);
      C_RD, C_RDA:    legal = (s == B_OPEN) || (((s == B_READ) || (s == B_WRITE)) && !a);
      C_WR, C_WRA:    legal = (s == B_OPEN) || ((s == B_WRITE) && !a);
      C_PRE:          legal = can_close(s, a);
      C_PREA:         legal = all_close;
      C_REF, C_MRS,
      C_EMRS:         legal = all_idle;
      C_MRSX:         legal = 1'b0;
      C_STOP:         legal = (s == B_READ) && !a;
      default:        legal = 1'b1;
    endcase
  end

endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank
  import sdcmd_pkg::*;
#(
  parameter int T_RCD   = 3,
  parameter int T_RP    = 3,
  parameter int T_RFC   = 10,
  parameter int T_WR    = 2,
  parameter int T_BURST = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     go,
  input  cmd_e     cmd,
  output bank_st_e st_o,
  output logic     ap_o
);

  localparam int TM1 = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int TM2 = (T_RFC > T_WR) ? T_RFC : T_WR;
  localparam int TM3 = (TM1 > TM2) ? TM1 : TM2;
  localparam int TMAX = (TM3 > T_BURST) ? TM3 : T_BURST;
  localparam int CW = $clog2(TMAX + 1);

  bank_st_e         st_q, t_st;
  logic [CW-1:0]    cnt_q, t_cnt;
  logic             ap_q, t_ap;

  // timer advance when no command acts on this bank
  always_comb begin
    t_st  = st_q;
    t_cnt = cnt_q;
    t_ap  = ap_q;
    if (cnt_q > CW'(1)) begin
      t_cnt = cnt_q - CW'(1);
    end else if (cnt_q == CW'(1)) begin
      t_cnt = '0;
      case (st_q)
        B_OPENING: t_st = B_OPEN;
        B_READ, B_WRREC: begin
          if (ap_q) begin
            t_st  = B_CLOSING;
            t_cnt = CW'(T_RP);
          end else begin
            t_st = B_OPEN;
          end
        end
        B_WRITE: begin
          t_st  = B_WRREC;
          t_cnt = CW'(T_WR);
        end
        default: begin
          t_st = B_IDLE;
          t_ap = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= B_IDLE;
      cnt_q <= '0;
      ap_q  <= 1'b0;
    end else if (go) begin
      case (cmd)
        C_ACT: begin
          st_q  <= B_OPENING;
          cnt_q <= CW'(T_RCD);
        end
        C_RD, C_RDA: begin
          st_q  <= B_READ;
          cnt_q <= CW'(T_BURST);
          ap_q  <= (cmd == C_RDA);
        end
        C_WR, C_WRA: begin
          st_q  <= B_WRITE;
          cnt_q <= CW'(T_BURST);
          ap_q  <= (cmd == C_WRA);
        end
        C_PRE, C_PREA: begin
          if (st_q inside {B_OPEN, B_READ, B_WRITE}) begin
            st_q  <= B_CLOSING;
            cnt_q <= CW'(T_RP);
            ap_q  <= 1'b0;
          end else begin
            st_q  <= t_st;
            cnt_q <= t_cnt;
            ap_q  <= t_ap;
          end
        end
        C_REF: begin
          st_q  <= B_REFRESH;
          cnt_q <= CW'(T_RFC);
        end
        C_STOP: begin
          st_q  <= B_OPEN;
          cnt_q <= '0;
        end
        default: begin
          st_q  <= t_st;
          cnt_q <= t_cnt;
          ap_q  <= t_ap;
        end
      endcase
    end else begin
      st_q  <= t_st;
      cnt_q <= t_cnt;
      ap_q  <= t_ap;
    end
  end

  assign st_o = st_q;
  assign ap_o = ap_q;

  // R4
  opening_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == B_OPENING) |=> (st_q inside {B_OPENING, B_OPEN}));

  // R5
  idle_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == B_IDLE) |=> (st_q inside {B_IDLE, B_OPENING, B_REFRESH}));

  // R9
  wr_ap_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == B_WRITE && ap_q) |=> (st_q inside {B_WRITE, B_WRREC}));

  // R11
  refresh_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == B_REFRESH) |=> (st_q inside {B_REFRESH, B_IDLE}));

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdcmd_pkg::*;
#(
  parameter int NB      = 4,
  parameter int T_RCD   = 3,
  parameter int T_RP    = 3,
  parameter int T_RFC   = 10,
  parameter int T_WR    = 2,
  parameter int T_BURST = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cke,
  input  logic                  cs_n,
  input  logic                  ras_n,
  input  logic                  cas_n,
  input  logic                  we_n,
  input  logic [$clog2(NB)-1:0] ba,
  input  logic                  a10,
  output logic [3:0]            cmd_o,
  output logic                  illegal_o,
  output logic                  pd_o,
  output logic [3*NB-1:0]       bank_st_o
);

  localparam int BAW = $clog2(NB);

  cmd_e          cmd;
  logic          legal;
  bank_st_e      st [NB];
  logic [NB-1:0] ap;
  logic [NB-1:0] go;

  sdcmd_decode #(.BAW(BAW)) u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .a10(a10), .cmd(cmd)
  );

  sdcmd_legal #(.NB(NB), .BAW(BAW)) u_legal (
    .cmd(cmd), .ba(ba), .st_i(st), .ap_i(ap), .legal(legal)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic hit;
    always_comb begin
      hit = (cmd inside {C_PREA, C_REF}) ||
            ((cmd inside {C_ACT, C_RD, C_RDA, C_WR, C_WRA, C_PRE, C_STOP}) &&
             (ba == BAW'(b)));
      go[b] = cke && legal && hit;
    end

    sdcmd_bank #(
      .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .T_WR(T_WR), .T_BURST(T_BURST)
    ) u_bank (
      .clk(clk), .rst(rst), .go(go[b]), .cmd(cmd), .st_o(st[b]), .ap_o(ap[b])
    );

    assign bank_st_o[3*b +: 3] = 3'(st[b]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o     <= 4'(C_NOP);
      illegal_o <= 1'b0;
      pd_o      <= 1'b0;
    end else begin
      cmd_o     <= cke ? 4'(cmd) : 4'(C_DESEL);
      illegal_o <= cke && !legal;
      pd_o      <= !cke;
    end
  end

  // R11
  refresh_all_chk: assert property (@(posedge clk) disable iff (rst)
    (st[0] == B_REFRESH) |-> (st[NB-1] == B_REFRESH));

  // R12
  pd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    pd_o |-> (!illegal_o && cmd_o == 4'(C_DESEL)));

endmodule

// File: tb/sim_sdram_cmd_tracker.sv
module sim_sdram_cmd_tracker;

  localparam int PERIOD = 10;
  localparam int NV = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b1;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = 2'd0;
  logic a10 = 1'b0;
  logic [3:0] cmd_o;
  logic illegal_o, pd_o;
  logic [11:0] bank_st_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  sdram_cmd_tracker u0 (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
    .cmd_o(cmd_o), .illegal_o(illegal_o), .pd_o(pd_o), .bank_st_o(bank_st_o)
  );

  // {cs_n, ras_n, cas_n, we_n, ba, a10, expected code, expected illegal}
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 4'd1,  1'b0},
    {1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd0,  1'b0},
    {1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd10, 1'b0},
    {1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 4'd11, 1'b0},
    {1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 4'd12, 1'b1},
    {1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 4'd12, 1'b1},
    {1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 4'd3,  1'b1},
    {1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 1'b1, 4'd6,  1'b1},
    {1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 4'd13, 1'b1},
    {1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 1'b0, 4'd7,  1'b0},
    {1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 4'd8,  1'b0}
  };

  function automatic int st(int b);
    return int'(bank_st_o[3*b +: 3]);
  endfunction

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // drive a command now (at a falling edge), return at the next falling edge
  task automatic issue(logic c, logic r, logic ca, logic w, logic [1:0] b, logic a);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; a10 = a;
    @(negedge clk);
    cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; ba = 2'd0; a10 = 1'b0;
  endtask

  task automatic act(logic [1:0] b);            issue(0, 0, 1, 1, b, 0);  endtask
  task automatic rd(logic [1:0] b, logic ap);   issue(0, 1, 0, 1, b, ap); endtask
  task automatic wr(logic [1:0] b, logic ap);   issue(0, 1, 0, 0, b, ap); endtask
  task automatic pre(logic [1:0] b, logic all); issue(0, 0, 1, 0, b, all); endtask
  task automatic refr();                        issue(0, 0, 0, 1, 2'd0, 0); endtask
  task automatic mrs(logic [1:0] b);            issue(0, 0, 0, 0, b, 0);  endtask
  task automatic stop(logic [1:0] b);           issue(0, 1, 1, 0, b, 0);  endtask
  task automatic nops(int n); repeat (n) @(negedge clk); endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    nops(3);
    // reset state
    chk("R3", "illegal in reset", int'(illegal_o), 0);
    chk("R4", "states in reset", int'(bank_st_o), 0);
    chk("R12", "pd in reset", int'(pd_o), 0);
    rst = 1'b0;
    nops(1);

    // R1 R2 R5 R7 R10: decode table from all-idle, no state change
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:6], VEC[i][5]);
      chk("R1", $sformatf("code vec %0d", i), int'(cmd_o), int'(VEC[i][4:1]));
      chk("R2_R5", $sformatf("illegal vec %0d", i), int'(illegal_o), int'(VEC[i][0]));
      chk("R3", $sformatf("states vec %0d", i), int'(bank_st_o), 0);
    end

    // R4 open row timing
    act(2'd0);
    chk("R4", "opening", st(0), 1);
    chk("R1", "act code", int'(cmd_o), 2);
    nops(2);
    chk("R4", "opening last", st(0), 1);
    nops(1);
    chk("R4", "row open", st(0), 2);
    act(2'd0);
    chk("R4", "act on open illegal", int'(illegal_o), 1);
    chk("R3", "state kept", st(0), 2);
    nops(1);
    chk("R3", "flag one cycle", int'(illegal_o), 0);

    // R6 read restart
    rd(2'd0, 1'b0);
    chk("R6", "reading", st(0), 3);
    rd(2'd0, 1'b0);
    chk("R6", "restart legal", int'(illegal_o), 0);
    nops(1);
    chk("R6", "still reading after restart", st(0), 3);
    nops(1);
    chk("R6", "back to open", st(0), 2);
    // R6 write during read
    rd(2'd0, 1'b0);
    wr(2'd0, 1'b0);
    chk("R6", "write in read illegal", int'(illegal_o), 1);
    chk("R6", "still reading", st(0), 3);
    nops(1);
    chk("R6", "burst ended", st(0), 2);
    // R7 burst stop
    rd(2'd0, 1'b0);
    stop(2'd0);
    chk("R7", "stop legal", int'(illegal_o), 0);
    chk("R7", "open at once", st(0), 2);
    stop(2'd0);
    chk("R7", "stop on open illegal", int'(illegal_o), 1);

    // R8 write and recovery
    wr(2'd0, 1'b0);
    chk("R8", "writing", st(0), 4);
    stop(2'd0);
    chk("R7", "stop in write illegal", int'(illegal_o), 1);
    chk("R8", "still writing", st(0), 4);
    nops(1);
    chk("R8", "recovery", st(0), 5);
    rd(2'd0, 1'b0);
    chk("R5", "read in recovery illegal", int'(illegal_o), 1);
    nops(1);
    chk("R8", "open after recovery", st(0), 2);

    // R9 read with auto-precharge
    rd(2'd0, 1'b1);
    chk("R1", "reada code", int'(cmd_o), 4);
    rd(2'd0, 1'b0);
    chk("R9", "read in ap read illegal", int'(illegal_o), 1);
    chk("R9", "ap reading", st(0), 3);
    nops(1);
    chk("R9", "ap closing", st(0), 6);
    nops(2);
    chk("R9", "closing last", st(0), 6);
    nops(1);
    chk("R9", "idle after ap", st(0), 0);

    // R9 write with auto-precharge on bank 1
    act(2'd1);
    nops(3);
    chk("R4", "bank1 open", st(1), 2);
    wr(2'd1, 1'b1);
    wr(2'd1, 1'b0);
    chk("R9", "write in ap write illegal", int'(illegal_o), 1);
    chk("R9", "ap writing", st(1), 4);
    nops(1);
    chk("R9", "ap recovery", st(1), 5);
    nops(1);
    chk("R9", "ap recovery last", st(1), 5);
    nops(1);
    chk("R9", "ap closing w", st(1), 6);
    nops(2);
    chk("R9", "ap closing w last", st(1), 6);
    nops(1);
    chk("R9", "idle after wa", st(1), 0);

    // R10 R11 precharge and refresh rules on bank 2
    act(2'd2);
    refr();
    chk("R11", "refresh with busy bank illegal", int'(illegal_o), 1);
    pre(2'd2, 1'b0);
    chk("R10", "pre while opening illegal", int'(illegal_o), 1);
    chk("R10", "still opening", st(2), 1);
    nops(1);
    chk("R4", "bank2 open", st(2), 2);
    mrs(2'd0);
    chk("R2", "mrs with open bank illegal", int'(illegal_o), 1);
    pre(2'd2, 1'b1);
    chk("R10", "prea legal", int'(illegal_o), 0);
    chk("R10", "bank2 closing", st(2), 6);
    chk("R10", "bank0 untouched", st(0), 0);
    nops(2);
    chk("R10", "closing last", st(2), 6);
    nops(1);
    chk("R10", "bank2 idle", st(2), 0);

    // R11 refresh all
    refr();
    chk("R11", "all refreshing", int'(bank_st_o), 12'o7777);
    mrs(2'd0);
    chk("R11", "mrs in refresh illegal", int'(illegal_o), 1);
    nops(8);
    chk("R11", "refresh last", int'(bank_st_o), 12'o7777);
    nops(1);
    chk("R11", "all idle after refresh", int'(bank_st_o), 0);

    // R12 power-down ignores pins
    cke = 1'b0;
    act(2'd3);
    chk("R12", "pd flag", int'(pd_o), 1);
    chk("R12", "code in pd", int'(cmd_o), 0);
    chk("R12", "no flag in pd", int'(illegal_o), 0);
    chk("R12", "bank3 unchanged", st(3), 0);
    cke = 1'b1;
    nops(1);
    chk("R12", "pd cleared", int'(pd_o), 0);
    chk("R12", "bank3 still idle", st(3), 0);

    // R10 precharge-all refused by an ap read
    act(2'd3);
    nops(3);
    rd(2'd3, 1'b1);
    pre(2'd0, 1'b1);
    chk("R10", "prea with ap burst illegal", int'(illegal_o), 1);
    chk("R10", "bank3 reading", st(3), 3);
    nops(1);
    chk("R9", "bank3 closing", st(3), 6);
    nops(3);
    chk("R9", "bank3 idle", st(3), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule